// File: doc/BRIEF.md
# Descriptor QoS and Destination Resolver

This block turns the classification fields of one received descriptor into the controls that a transmit path needs. It picks a 3-bit traffic identifier (TID) and says whether that TID overrides the default. It also produces the flow-override controls, a drop colour, and a decoded destination port. The TID comes from the first of three sources that applies. The first is a flag-driven override that also enables flow override. The second is an override requested by bit 7 of the QoS byte. The third is a lookup of the internal priority in a programmable table, and it is used only when the destination port allows it.

A per-virtual-port table holds two enables for each port: priority-to-TID mapping and drop colouring. A 16-entry table maps the 4-bit internal priority to a TID. Both tables are loaded through one write port. A descriptor presented with `desc_valid_i` produces its result on the outputs one clock later, flagged by `res_valid_o`. The outputs keep their values until the next descriptor arrives.

Top module: `qos_dest_resolver`

## Requirements
- R1: A descriptor accepted with `desc_valid_i` high at a clock edge puts its result on the outputs at that edge. `res_valid_o` is high for exactly that one cycle. When no descriptor is accepted, the result outputs keep their values. After reset, `res_valid_o`=0, `tid_ovr_o`=0 and `colour_o`=3.
- R2: With `qos_flag_i`=1, the outputs are taken from the QoS byte: `tid_o` is bits 3:1, `flow_ovr_o` is bit 0 and `cls_sel_o` is bits 5:4. `tid_ovr_o` and `flow_ovr_en_o` are both 1. This source wins over the other two.
- R3: With `qos_flag_i`=0 and QoS bit 7 set, `tid_o` is bits 3:1 and `tid_ovr_o`=1. `flow_ovr_en_o`, `flow_ovr_o` and `cls_sel_o` are all 0. This source wins over the priority table.
- R4: With `qos_flag_i`=0, QoS bit 7 clear and the mapping enable of the destination virtual port set, `tid_o` is the priority table entry selected by `int_pri_i`, and `tid_ovr_o`=1.
- R5: When none of the three sources applies, `tid_ovr_o`=0 and `tid_o`=0. The flow and class outputs are also 0.
- R6: Bit 6 of the QoS byte has no effect on any output.
- R7: `colour_o` is green=0, yellow=1, red=2 and colourless=3. `drop_prec_i` values 0, 1 and 2 are passed through only when the colour enable of the destination port is set. Otherwise, and always for the value 3, the output is 3.
- R8: `dst_info_i[15:12]` is the destination type. Only type 2 (port identifier) is processed. Types 0 (invalid), 1 (next hop), 3 (bitmap) and all others set `dest_err_o`=1.
- R9: For type 2 destinations, `dst_info_i[11:0]` is the port identifier. Identifiers 0..31 are physical ports: `dest_virt_o`=0 and both enables read as 0. Identifiers 64..255 are virtual ports: `dest_virt_o`=1 and the port table is used. Identifiers 32..63 and identifiers above 255 set `dest_err_o`=1. Whenever `dest_err_o`=1, `dest_port_o`=0 and both enables read as 0.
- R10: A write with `cfg_tbl_i`=0 goes to the port table at port `cfg_addr_i`. Bit 0 of `cfg_wdata_i` is the mapping enable and bit 1 is the colour enable. Writes to addresses below 64 are ignored. A write with `cfg_tbl_i`=1 sets priority entry `cfg_addr_i[3:0]` to `cfg_wdata_i[2:0]`. Both tables reset to zero.
- R11: A lookup in the same cycle as a write to the entry it reads uses the contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| desc_valid_i | input | 1 | Descriptor fields valid this cycle |
| qos_flag_i | input | 1 | QoS flag of the descriptor |
| qos_byte_i | input | 8 | QoS byte |
| int_pri_i | input | 4 | Internal priority |
| drop_prec_i | input | 2 | Drop precedence |
| dst_info_i | input | 16 | Destination type (15:12) and port identifier (11:0) |
| cfg_we_i | input | 1 | Table write strobe |
| cfg_tbl_i | input | 1 | Table select: 0 port table, 1 priority table |
| cfg_addr_i | input | 8 | Table write address |
| cfg_wdata_i | input | 3 | Table write data |
| res_valid_o | output | 1 | Result valid |
| tid_o | output | 3 | Traffic identifier |
| tid_ovr_o | output | 1 | TID override enable |
| flow_ovr_en_o | output | 1 | Flow override enable |
| flow_ovr_o | output | 1 | Flow override value |
| cls_sel_o | output | 2 | Classify-info select |
| colour_o | output | 2 | Drop colour |
| dest_virt_o | output | 1 | Destination is a virtual port |
| dest_port_o | output | 8 | Decoded port identifier |
| dest_err_o | output | 1 | Destination unsupported or reserved |

## Verification
The hardest case to reach is a table write that lands in the same cycle as a lookup of the entry being written. The stimulus drives the port-table write and a descriptor for that same virtual port on one clock edge. It expects the colourless result from the old contents, then sends the descriptor again and expects the new colour. A second difficult case is a port whose enables are set but whose destination decodes as an error or as a physical port. Enables are first programmed for a virtual port. The descriptor then reaches that same identifier with a wrong type field, or carries a physical identifier whose table write was dropped. Both enables must read as zero in these cases.

// File: rtl/qdr_pkg.sv
package qdr_pkg;
  localparam int TID_W = 3;
  localparam int QOS_W = 8;
  localparam int CLS_W = 2;
  localparam int COL_W = 2;

  localparam logic [COL_W-1:0] COL_NONE = 2'd3;
  localparam logic [1:0]       PREC_BAD = 2'd3;

  typedef struct packed {
    logic [TID_W-1:0] tid;
    logic             tid_ovr;
    logic             flow_en;
    logic             flow_ovr;
    logic [CLS_W-1:0] cls_sel;
  } tid_res_t;
endpackage

// File: rtl/qdr_reg_table.sv
module qdr_reg_table #(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 2,
  parameter int BASE    = 64,
  parameter int ENTRIES = 192
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [ADDR_W:0] BASE_C = (ADDR_W+1)'(BASE);
  localparam logic [ADDR_W:0] ENT_C  = (ADDR_W+1)'(ENTRIES);

  logic [ADDR_W:0]   woff, roff;
  logic              whit, rhit;
  logic [DATA_W-1:0] ent [ENTRIES];

  // offsets below BASE wrap high and fail the range test
  assign woff = {1'b0, waddr_i} - BASE_C;
  assign roff = {1'b0, raddr_i} - BASE_C;
  assign whit = we_i && (woff < ENT_C);
  assign rhit = roff < ENT_C;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic [DATA_W-1:0] ent_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    ent_q <= '0;
      else if (whit && woff[IDX_W-1:0] == IDX_W'(g)) ent_q <= wdata_i;
    end
    assign ent[g] = ent_q;
  end

  assign rdata_o = rhit ? ent[roff[IDX_W-1:0]] : '0;
endmodule

// File: rtl/qdr_dest_decode.sv
module qdr_dest_decode #(
  parameter int TYPE_W    = 4,
  parameter int PORT_ID_W = 12,
  parameter int PID_W     = 8,
  parameter int LAG_LO    = 32,
  parameter int VPORT_LO  = 64,
  parameter int PORT_TYPE = 2
) (
  input  logic [TYPE_W+PORT_ID_W-1:0] dst_i,
  output logic                        ok_o,
  output logic                        virt_o,
  output logic [PID_W-1:0]            port_o
);
  localparam int DST_W = TYPE_W + PORT_ID_W;
  localparam logic [PORT_ID_W-1:0] LAG_C   = PORT_ID_W'(LAG_LO);
  localparam logic [PORT_ID_W-1:0] VPORT_C = PORT_ID_W'(VPORT_LO);
  localparam logic [PORT_ID_W-1:0] LIM_C   = PORT_ID_W'(2 ** PID_W);
  localparam logic [TYPE_W-1:0]    TYPE_C  = TYPE_W'(PORT_TYPE);

  logic [TYPE_W-1:0]    kind;
  logic [PORT_ID_W-1:0] id;
  logic                 type_ok, id_ok;

  assign kind    = dst_i[DST_W-1 -: TYPE_W];
  assign id      = dst_i[PORT_ID_W-1:0];
  assign type_ok = kind == TYPE_C;
  assign id_ok   = (id < LIM_C) && ((id < LAG_C) || (id >= VPORT_C));

  assign ok_o   = type_ok && id_ok;
  assign virt_o = ok_o && (id >= VPORT_C);
  assign port_o = ok_o ? id[PID_W-1:0] : '0;
endmodule

// File: rtl/qdr_tid_select.sv
module qdr_tid_select
  import qdr_pkg::*;
(
  input  logic             flag_i,
  input  logic [QOS_W-1:0] qos_i,
  input  logic             map_en_i,
  input  logic [TID_W-1:0] map_tid_i,
  output tid_res_t         res_o
);
  logic unused_qos6;
  assign unused_qos6 = qos_i[6];

  // precedence: flag, then qos bit 7, then port-enabled priority map
  always_comb begin
    res_o = '0;
    if (flag_i) begin
      res_o.tid      = qos_i[3:1];
      res_o.tid_ovr  = 1'b1;
      res_o.flow_en  = 1'b1;
      res_o.flow_ovr = qos_i[0];
      res_o.cls_sel  = qos_i[5:4];
    end else if (qos_i[7]) begin
      res_o.tid     = qos_i[3:1];
      res_o.tid_ovr = 1'b1;
    end else if (map_en_i) begin
      res_o.tid     = map_tid_i;
      res_o.tid_ovr = 1'b1;
    end
  end
endmodule

// File: rtl/qos_dest_resolver.sv
module qos_dest_resolver
  import qdr_pkg::*;
#(
  parameter int PRI_W     = 4,
  parameter int PID_W     = 8,
  parameter int TYPE_W    = 4,
  parameter int PORT_ID_W = 12,
  parameter int LAG_LO    = 32,
  parameter int VPORT_LO  = 64
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        desc_valid_i,
  input  logic                        qos_flag_i,
  input  logic [7:0]                  qos_byte_i,
  input  logic [PRI_W-1:0]            int_pri_i,
  input  logic [1:0]                  drop_prec_i,
  input  logic [TYPE_W+PORT_ID_W-1:0] dst_info_i,
  input  logic                        cfg_we_i,
  input  logic                        cfg_tbl_i,
  input  logic [PID_W-1:0]            cfg_addr_i,
  input  logic [2:0]                  cfg_wdata_i,
  output logic                        res_valid_o,
  output logic [2:0]                  tid_o,
  output logic                        tid_ovr_o,
  output logic                        flow_ovr_en_o,
  output logic                        flow_ovr_o,
  output logic [1:0]                  cls_sel_o,
  output logic [1:0]                  colour_o,
  output logic                        dest_virt_o,
  output logic [PID_W-1:0]            dest_port_o,
  output logic                        dest_err_o
);
  localparam int VPORTS = 2 ** PID_W - VPORT_LO;
  localparam int PRIS   = 2 ** PRI_W;

  logic             dec_ok, dec_virt;
  logic [PID_W-1:0] dec_port;
  logic [1:0]       port_en;
  logic [TID_W-1:0] map_tid;
  logic             en_map, en_col;
  tid_res_t         sel;
  logic [COL_W-1:0] col_d;

  qdr_dest_decode #(
    .TYPE_W(TYPE_W), .PORT_ID_W(PORT_ID_W), .PID_W(PID_W),
    .LAG_LO(LAG_LO), .VPORT_LO(VPORT_LO), .PORT_TYPE(2)
  ) i_dec (
    .dst_i(dst_info_i), .ok_o(dec_ok), .virt_o(dec_virt), .port_o(dec_port)
  );

  qdr_reg_table #(
    .ADDR_W(PID_W), .DATA_W(2), .BASE(VPORT_LO), .ENTRIES(VPORTS)
  ) i_port_tbl (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i && !cfg_tbl_i), .waddr_i(cfg_addr_i),
    .wdata_i(cfg_wdata_i[1:0]), .raddr_i(dec_port), .rdata_o(port_en)
  );

  qdr_reg_table #(
    .ADDR_W(PRI_W), .DATA_W(TID_W), .BASE(0), .ENTRIES(PRIS)
  ) i_pri_tbl (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i && cfg_tbl_i), .waddr_i(cfg_addr_i[PRI_W-1:0]),
    .wdata_i(cfg_wdata_i[TID_W-1:0]), .raddr_i(int_pri_i), .rdata_o(map_tid)
  );

  // enables only count for a decoded virtual port
  assign en_map = dec_virt && port_en[0];
  assign en_col = dec_virt && port_en[1];

  qdr_tid_select i_tid (
    .flag_i(qos_flag_i), .qos_i(qos_byte_i), .map_en_i(en_map),
    .map_tid_i(map_tid), .res_o(sel)
  );

  assign col_d = (en_col && drop_prec_i != PREC_BAD) ? drop_prec_i : COL_NONE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o   <= 1'b0;
      tid_o         <= '0;
      tid_ovr_o     <= 1'b0;
      flow_ovr_en_o <= 1'b0;
      flow_ovr_o    <= 1'b0;
      cls_sel_o     <= '0;
      colour_o      <= COL_NONE;
      dest_virt_o   <= 1'b0;
      dest_port_o   <= '0;
      dest_err_o    <= 1'b0;
    end else begin
      res_valid_o <= desc_valid_i;
      if (desc_valid_i) begin
        tid_o         <= sel.tid;
        tid_ovr_o     <= sel.tid_ovr;
        flow_ovr_en_o <= sel.flow_en;
        flow_ovr_o    <= sel.flow_ovr;
        cls_sel_o     <= sel.cls_sel;
        colour_o      <= col_d;
        dest_virt_o   <= dec_virt;
        dest_port_o   <= dec_port;
        dest_err_o    <= !dec_ok;
      end
    end
  end
endmodule

// File: rtl/qdr_checker.sv
module qdr_checker #(
  parameter int PRI_W     = 4,
  parameter int PID_W     = 8,
  parameter int TYPE_W    = 4,
  parameter int PORT_ID_W = 12
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        desc_valid_i,
  input logic                        qos_flag_i,
  input logic [7:0]                  qos_byte_i,
  input logic [PRI_W-1:0]            int_pri_i,
  input logic [1:0]                  drop_prec_i,
  input logic [TYPE_W+PORT_ID_W-1:0] dst_info_i,
  input logic                        cfg_we_i,
  input logic                        cfg_tbl_i,
  input logic [PID_W-1:0]            cfg_addr_i,
  input logic [2:0]                  cfg_wdata_i,
  input logic                        res_valid_o,
  input logic [2:0]                  tid_o,
  input logic                        tid_ovr_o,
  input logic                        flow_ovr_en_o,
  input logic                        flow_ovr_o,
  input logic [1:0]                  cls_sel_o,
  input logic [1:0]                  colour_o,
  input logic                        dest_virt_o,
  input logic [PID_W-1:0]            dest_port_o,
  input logic                        dest_err_o
);
  p_valid_latency_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_valid_i |=> res_valid_o);
  p_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !desc_valid_i |=> $stable(tid_o) && $stable(colour_o) && $stable(dest_port_o));
  p_flag_path_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_valid_i && qos_flag_i |=> tid_ovr_o && flow_ovr_en_o
      && tid_o == $past(qos_byte_i[3:1]) && cls_sel_o == $past(qos_byte_i[5:4]));
  p_bit7_path_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_valid_i && !qos_flag_i && qos_byte_i[7] |=> tid_ovr_o && !flow_ovr_en_o
      && tid_o == $past(qos_byte_i[3:1]));
  p_no_ovr_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o && !tid_ovr_o |-> tid_o == 3'd0 && !flow_ovr_en_o);
  p_bad_prec_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_valid_i && drop_prec_i == 2'd3 |=> colour_o == 2'd3);
  p_bad_type_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_valid_i && dst_info_i[15:12] != 4'd2 |=> dest_err_o);
  p_err_gates_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o && dest_err_o |-> dest_port_o == '0 && colour_o == 2'd3 && !dest_virt_o);
endmodule

bind qos_dest_resolver qdr_checker #(
  .PRI_W(PRI_W), .PID_W(PID_W), .TYPE_W(TYPE_W), .PORT_ID_W(PORT_ID_W)
) i_qdr_checker (.*);

// File: tb/test_qos_dest_resolver.sv
`timescale 1ns/1ps
module test_qos_dest_resolver;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        desc_valid = 1'b0, qos_flag = 1'b0;
  logic [7:0]  qos_byte = '0;
  logic [3:0]  int_pri = '0;
  logic [1:0]  drop_prec = '0;
  logic [15:0] dst_info = '0;
  logic        cfg_we = 1'b0, cfg_tbl = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [2:0]  cfg_wdata = '0;
  logic        res_valid, tid_ovr, flow_en, flow_ovr, dest_virt, dest_err;
  logic [2:0]  tid;
  logic [1:0]  cls_sel, colour;
  logic [7:0]  dest_port;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  qos_dest_resolver i_qos_dest_resolver (
    .clk_i(clk), .rst_ni(rst_n), .desc_valid_i(desc_valid), .qos_flag_i(qos_flag),
    .qos_byte_i(qos_byte), .int_pri_i(int_pri), .drop_prec_i(drop_prec),
    .dst_info_i(dst_info), .cfg_we_i(cfg_we), .cfg_tbl_i(cfg_tbl),
    .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata), .res_valid_o(res_valid),
    .tid_o(tid), .tid_ovr_o(tid_ovr), .flow_ovr_en_o(flow_en), .flow_ovr_o(flow_ovr),
    .cls_sel_o(cls_sel), .colour_o(colour), .dest_virt_o(dest_virt),
    .dest_port_o(dest_port), .dest_err_o(dest_err)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_tid(input string req, input int t, input int ovr, input int fen,
                         input int fo, input int cls);
    chk(req, "tid", tid, t);
    chk(req, "tid_ovr", tid_ovr, ovr);
    chk(req, "flow_en", flow_en, fen);
    chk(req, "flow_ovr", flow_ovr, fo);
    chk(req, "cls_sel", cls_sel, cls);
  endtask

  task automatic cfg_write(input logic tbl, input logic [7:0] addr, input logic [2:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_tbl = tbl; cfg_addr = addr; cfg_wdata = data;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // result is sampled at the negedge following the capturing edge
  task automatic send(input logic flag, input logic [7:0] qb, input logic [3:0] pri,
                      input logic [1:0] prec, input logic [15:0] dst);
    @(negedge clk);
    desc_valid = 1'b1; qos_flag = flag; qos_byte = qb; int_pri = pri;
    drop_prec = prec; dst_info = dst;
    @(posedge clk);
    @(negedge clk);
    desc_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1", "reset valid", res_valid, 0);
    chk("R1", "reset tid_ovr", tid_ovr, 0);
    chk("R1", "reset colour", colour, 3);
  endtask

  task automatic t_latency_hold;
    send(1'b1, 8'h2B, 4'd0, 2'd0, 16'h2005);
    chk("R1", "valid pulse", res_valid, 1);
    @(negedge clk);
    chk("R1", "valid drops", res_valid, 0);
    qos_byte = 8'h00; dst_info = 16'h0000; drop_prec = 2'd1;
    @(negedge clk);
    chk("R1", "tid held", tid, 5);
    chk("R1", "port held", dest_port, 5);
  endtask

  task automatic t_flag;
    send(1'b1, 8'h2B, 4'd0, 2'd0, 16'h2005);
    chk_tid("R2", 5, 1, 1, 1, 2);
    send(1'b1, 8'h9C, 4'd9, 2'd0, 16'h2064);
    chk_tid("R2", 6, 1, 1, 0, 1);
  endtask

  task automatic t_bit7;
    send(1'b0, 8'hBC, 4'd0, 2'd0, 16'h2005);
    chk_tid("R3", 6, 1, 0, 0, 0);
  endtask

  task automatic t_map;
    cfg_write(1'b1, 8'd9, 3'd3);
    cfg_write(1'b0, 8'd100, 3'b001);
    send(1'b0, 8'h00, 4'd9, 2'd0, 16'h2064);
    chk_tid("R4", 3, 1, 0, 0, 0);
    send(1'b0, 8'h82, 4'd9, 2'd0, 16'h2064);
    chk_tid("R3", 1, 1, 0, 0, 0);
    send(1'b0, 8'h3F, 4'd9, 2'd0, 16'h2065);
    chk_tid("R5", 0, 0, 0, 0, 0);
    send(1'b0, 8'h00, 4'd9, 2'd0, 16'h2005);
    chk_tid("R9", 0, 0, 0, 0, 0);
  endtask

  task automatic t_bit6;
    send(1'b0, 8'h40, 4'd9, 2'd0, 16'h2064);
    chk_tid("R6", 3, 1, 0, 0, 0);
    send(1'b0, 8'h40, 4'd9, 2'd0, 16'h2065);
    chk_tid("R6", 0, 0, 0, 0, 0);
    send(1'b1, 8'h6B, 4'd0, 2'd0, 16'h2005);
    chk_tid("R6", 5, 1, 1, 1, 2);
  endtask

  task automatic t_colour;
    cfg_write(1'b0, 8'd120, 3'b010);
    for (int p = 0; p < 4; p++) begin
      send(1'b0, 8'h00, 4'd0, 2'(p), 16'h2078);
      chk("R7", "colour enabled", colour, (p == 3) ? 3 : p);
    end
    send(1'b0, 8'h00, 4'd0, 2'd1, 16'h2079);
    chk("R7", "colour disabled port", colour, 3);
    send(1'b0, 8'h00, 4'd0, 2'd2, 16'h2064);
    chk("R7", "map-only port", colour, 3);
  endtask

  task automatic t_dest;
    send(1'b0, 8'h00, 4'd0, 2'd0, 16'h0005);
    chk("R8", "type0 err", dest_err, 1);
    chk("R8", "type0 port", dest_port, 0);
    send(1'b0, 8'h00, 4'd0, 2'd0, 16'h1005);
    chk("R8", "type1 err", dest_err, 1);
    send(1'b0, 8'h00, 4'd0, 2'd0, 16'h7005);
    chk("R8", "type7 err", dest_err, 1);
    send(1'b0, 8'h00, 4'd0, 2'd0, 16'h201F);
    chk("R9", "phys31 err", dest_err, 0);
    chk("R9", "phys31 virt", dest_virt, 0);
    chk("R9", "phys31 port", dest_port, 31);
    send(1'b0, 8'h00, 4'd0, 2'd0, 16'h2020);
    chk("R9", "lag32 err", dest_err, 1);
    send(1'b0, 8'h00, 4'd0, 2'd0, 16'h203F);
    chk("R9", "lag63 err", dest_err, 1);
    send(1'b0, 8'h00, 4'd0, 2'd0, 16'h2040);
    chk("R9", "v64 virt", dest_virt, 1);
    chk("R9", "v64 port", dest_port, 64);
    send(1'b0, 8'h00, 4'd0, 2'd0, 16'h20FF);
    chk("R9", "v255 port", dest_port, 255);
    chk("R9", "v255 err", dest_err, 0);
    send(1'b0, 8'h00, 4'd0, 2'd0, 16'h2100);
    chk("R9", "id256 err", dest_err, 1);
    chk("R9", "id256 port", dest_port, 0);
    // port 100 has the map enable and port 120 the colour enable; a bitmap type must not reach either
    send(1'b0, 8'h00, 4'd9, 2'd1, 16'h3064);
    chk("R9", "err no map", tid_ovr, 0);
    send(1'b0, 8'h00, 4'd0, 2'd1, 16'h3078);
    chk("R9", "err no colour", colour, 3);
    chk("R8", "bitmap err", dest_err, 1);
  endtask

  task automatic t_phys_write;
    cfg_write(1'b0, 8'd10, 3'b011);
    send(1'b0, 8'h00, 4'd9, 2'd1, 16'h200A);
    chk("R10", "phys write colour", colour, 3);
    chk("R10", "phys write map", tid_ovr, 0);
    cfg_write(1'b1, 8'd15, 3'd7);
    cfg_write(1'b0, 8'd200, 3'b011);
    send(1'b0, 8'h00, 4'd15, 2'd2, 16'h20C8);
    chk("R10", "pri entry 15", tid, 7);
    chk("R10", "both enables colour", colour, 2);
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    cfg_we = 1'b1; cfg_tbl = 1'b0; cfg_addr = 8'd130; cfg_wdata = 3'b010;
    desc_valid = 1'b1; qos_flag = 1'b0; qos_byte = 8'h00; int_pri = 4'd0;
    drop_prec = 2'd2; dst_info = 16'h2082;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0; desc_valid = 1'b0;
    chk("R11", "old contents", colour, 3);
    send(1'b0, 8'h00, 4'd0, 2'd2, 16'h2082);
    chk("R11", "new contents", colour, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_latency_hold();
    t_flag();
    t_bit7();
    t_map();
    t_bit6();
    t_colour();
    t_dest();
    t_phys_write();
    t_same_cycle();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule